// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the low-order address bits for a fixed-length burst into a synchronous pipelined memory. When an access starts, a load strobe captures the starting low address bits and the wanted ordering. An active-low advance strobe then moves the address to the next burst position, one beat per clock edge. After the last beat the sequence wraps back to the start.

Two orderings are supported. Linear ordering adds the beat index to the start address, modulo the burst length. Interleaved ordering XORs the beat index into the start address. The higher address bits, the memory array, chip selects and the data path are all handled outside the block.

Both outputs come from registers. Each output reflects the clock edge that just passed, with no further pipeline stage.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `beat_o` and `baddr_o` become 0 after that edge.
- R2: When `start_i` is high at a rising edge, after that edge `beat_o` is 0 and `baddr_o` equals the `seed_i` value sampled at that edge.
- R3: A load takes priority over an advance: with `start_i` high and `adv_n` low at the same edge, the result is the same as a plain load (R2).
- R4: When `mode_i` was 1 at the most recent load, the ordering is interleaved: `baddr_o` equals `seed XOR beat_o`. From seed 01 the sequence is 01,00,11,10. From seed 10 it is 10,11,00,01.
- R5: When `mode_i` was 0 at the most recent load, the ordering is linear: `baddr_o` equals `(seed + beat_o) mod 4`. From seed 10 the sequence is 10,11,00,01.
- R6: With `start_i` low, `beat_o` increments by one at each edge where `adv_n` is low. At each edge where `adv_n` is high, `beat_o` and `baddr_o` keep their values.
- R7: After four advances following a load, `beat_o` returns to 0 and `baddr_o` returns to the start address.
- R8: `mode_i` is sampled only at a load. Changing `mode_i` during a burst has no effect on `baddr_o` until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Load strobe: capture the start address and ordering mode |
| seed_i | input | ADDR_W (2) | Starting low address bits |
| adv_n | input | 1 | Advance strobe, active low |
| mode_i | input | 1 | Ordering select: 1 interleaved, 0 linear |
| baddr_o | output | ADDR_W (2) | Current burst address bits |
| beat_o | output | ADDR_W (2) | Beat index within the burst, 0 to 3 |

## Verification
The bench builds the block with the default `ADDR_W` of 2, which gives a four-beat burst. At this size every start value can be run under both orderings, and each run can go through a full wrap back to its start. That exhausts the whole ordering table and puts every modulo carry within reach. Random runs then mix loads, advances, holds and mid-burst mode changes, and those runs check the priority rule and the rule that mode is sampled only at a load.

// File: rtl/burst_pkg.sv
// Package burst_pkg
// Holds the ordering type that the burst address sequencer shares with its submodules.
// Assumes: the burst length is a power of two.
package burst_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

endpackage

// File: rtl/burst_start_reg.sv
// Module burst_start_reg
// Captures the start address and the ordering mode when a burst is loaded.
// Assumes: start_i is synchronous to clk. The values are held until the next load.
module burst_start_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] seed_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] base_o,
    output order_e            order_o
);

    // Capture the seed and the ordering at load. Clear both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o  <= '0;
            order_o <= ORD_LINEAR;
        end else if (start_i) begin
            base_o  <= seed_i;
            order_o <= order_e'(mode_i);
        end
    end

endmodule

// File: rtl/burst_beat_ctr.sv
// Module burst_beat_ctr
// Wrapping beat index. A load clears it, and an active-low advance steps it.
// Assumes: the load has priority over the advance.
module burst_beat_ctr #(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              adv_n,
    output logic [ADDR_W-1:0] beat_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    // Clear on reset or load. Otherwise step on advance, wrapping at the burst length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_o <= '0;
        end else if (start_i) begin
            beat_o <= '0;
        end else if (!adv_n) begin
            beat_o <= beat_o + STEP;
        end
    end

endmodule

// File: rtl/burst_order_map.sv
// Module burst_order_map
// Combinational map from (base, beat, ordering) to the burst address.
// Assumes: both inputs come straight from registers, so the output is glitch-tolerant.
module burst_order_map
    import burst_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] beat_i,
    input  order_e            order_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] inter_addr;
    logic [ADDR_W-1:0] lin_addr;
    logic [ADDR_W:0]   carry;

    assign carry[0] = 1'b0;

    // One slice per address bit: an XOR for interleaving and a full-adder for linear.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        assign inter_addr[b] = base_i[b] ^ beat_i[b];
        assign lin_addr[b]   = base_i[b] ^ beat_i[b] ^ carry[b];
        assign carry[b+1]    = (base_i[b] & beat_i[b]) | (carry[b] & (base_i[b] ^ beat_i[b]));
    end

    // Select the ordering that was captured at load.
    always_comb begin
        addr_o = (order_i == ORD_INTERLEAVE) ? inter_addr : lin_addr;
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Module burst_addr_gen
// Top of the burst address sequencer. It loads a start address and steps
// through a 2**ADDR_W beat burst in linear or interleaved order.
// Assumes: a synchronous active-low reset. All inputs are synchronous to clk.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] seed_i,
    input  logic              adv_n,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] baddr_o,
    output logic [ADDR_W-1:0] beat_o
);

    logic [ADDR_W-1:0] base;
    order_e            order;

    burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .seed_i  (seed_i),
        .mode_i  (mode_i),
        .base_o  (base),
        .order_o (order)
    );

    burst_beat_ctr #(.ADDR_W(ADDR_W)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .adv_n   (adv_n),
        .beat_o  (beat_o)
    );

    burst_order_map #(.ADDR_W(ADDR_W)) u_map (
        .base_i  (base),
        .beat_i  (beat_o),
        .order_i (order),
        .addr_o  (baddr_o)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module burst_addr_gen_chk
// Temporal checks on the ports of burst_addr_gen. It is attached by bind.
// Assumes: it sees the same clock and reset as the design.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] seed_i,
    input logic              adv_n,
    input logic              mode_i,
    input logic [ADDR_W-1:0] baddr_o,
    input logic [ADDR_W-1:0] beat_o
);

    logic              mode_sh;
    logic [ADDR_W-1:0] xr_key;
    logic [ADDR_W-1:0] lin_key;

    // Shadow of the ordering that was requested at the last load.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_sh <= 1'b0;
        else if (start_i) mode_sh <= mode_i;
    end

    // Invariants of a burst: the start address recovered from the outputs.
    assign xr_key  = baddr_o ^ beat_o;
    assign lin_key = baddr_o - beat_o;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (beat_o == '0 && baddr_o == '0));

    // R2 and R3: a load wins, with or without an advance in the same cycle.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_o == '0 && baddr_o == $past(seed_i)));

    p_inter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sh && !start_i) |=> $stable(xr_key));

    p_linear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sh && !start_i) |=> $stable(lin_key));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && adv_n) |=> ($stable(beat_o) && $stable(baddr_o)));

    // R7: the step wraps modulo the burst length.
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !adv_n) |=> (beat_o == $past(beat_o) + ADDR_W'(1)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .seed_i  (seed_i),
    .adv_n   (adv_n),
    .mode_i  (mode_i),
    .baddr_o (baddr_o),
    .beat_o  (beat_o)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic [W-1:0] seed_i;
    logic         adv_n;
    logic         mode_i;
    logic [W-1:0] baddr_o;
    logic [W-1:0] beat_o;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model state
    int m_seed = 0;
    int m_beat = 0;
    int m_mode = 0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i),
        .adv_n(adv_n), .mode_i(mode_i), .baddr_o(baddr_o), .beat_o(beat_o)
    );

    function automatic int exp_addr(int s, int b, int m);
        return m ? ((s ^ b) & 3) : ((s + b) & 3);
    endfunction

    task automatic check(string tag, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // One clock: drive at the negedge, update the model at the posedge, check at the next negedge.
    task automatic cyc(bit st, bit adv, int sd, bit md, string tag);
        start_i = st; adv_n = adv; seed_i = W'(sd); mode_i = md;
        @(posedge clk);
        if (st) begin
            m_seed = sd & 3; m_beat = 0; m_mode = md;
        end else if (!adv) begin
            m_beat = (m_beat + 1) & 3;
        end
        @(negedge clk);
        check({tag, " beat"}, int'(beat_o), m_beat);
        check({tag, " addr"}, int'(baddr_o), exp_addr(m_seed, m_beat, m_mode));
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start_i = 1'b0; adv_n = 1'b0; seed_i = 2'd3; mode_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset beat", int'(beat_o), 0);
        check("R1 reset addr", int'(baddr_o), 0);
        rst_n = 1'b1;

        // R4/R5/R7: every seed, both orders, through a full wrap
        for (int md = 0; md < 2; md++) begin
            for (int sd = 0; sd < 4; sd++) begin
                cyc(1'b1, 1'b1, sd, md[0], "R2 load");
                for (int k = 0; k < 4; k++)
                    cyc(1'b0, 1'b0, 0, md[0], md ? "R4 interleave" : "R5 linear");
                check("R7 wrap addr", int'(baddr_o), sd);
                check("R7 wrap beat", int'(beat_o), 0);
            end
        end

        // R3: load with advance active
        cyc(1'b1, 1'b1, 2, 1'b0, "R2 load");
        cyc(1'b0, 1'b0, 0, 1'b0, "R6 adv");
        cyc(1'b1, 1'b0, 1, 1'b1, "R3 load beats adv");
        check("R3 beat zero", int'(beat_o), 0);

        // R6: hold with advance high
        cyc(1'b0, 1'b0, 0, 1'b1, "R6 adv");
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 3, 1'b0, "R6 hold");
        check("R6 hold addr", int'(baddr_o), 0);

        // R8: mode flip mid-burst has no effect
        cyc(1'b1, 1'b1, 1, 1'b0, "R2 load");
        cyc(1'b0, 1'b0, 0, 1'b1, "R8 mode ignored");
        check("R8 linear kept", int'(baddr_o), 2);
        cyc(1'b0, 1'b0, 0, 1'b1, "R8 mode ignored");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            bit st = ($urandom % 5) == 0;
            bit av = ($urandom % 3) == 0;
            cyc(st, av, int'($urandom % 4), 1'($urandom % 2), "R6 random");
        end

        // Reset in the middle of a burst
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m_seed = 0; m_beat = 0; m_mode = 0;
        check("R1 mid reset beat", int'(beat_o), 0);
        check("R1 mid reset addr", int'(baddr_o), 0);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule